// File: doc/BRIEF.md
# N-Buffered Banked Scratchpad

This block is an on-chip scratchpad shared by two stages of a coarse-grained pipeline. The address space is cut into `NBUF` equal logical buffers. The producer stage fills one buffer while the consumer stage drains another. Each stage moves on to the next buffer in ring order when it raises its done pulse, so a tile can be written, held and read with no copying.

Storage is split across `BANKS` single-write, single-read banks. Several vector lanes can therefore write, and several can read, in the same cycle. A mode register chooses how a logical word address maps to a bank. In block mode the upper address bits choose the bank. In interleaved mode the lower address bits choose it. Software picks the mode that spreads its lane addresses across distinct banks.

When two lanes of one port reach the same bank in one cycle, the lower-numbered lane is served and a conflict flag is raised. The producer cannot write the buffer the consumer holds: such writes are dropped and flagged.

Top module: `nbuf_scratchpad`

## Requirements
- R1: After reset the write buffer index is 0, the read buffer index is NBUF-1, the decode mode is block mode, and rd_valid, wr_blocked, wr_conflict and rd_conflict are all 0.
- R2: Each cycle with prod_done high moves wr_buf to the next index at the following edge, wrapping from NBUF-1 to 0. Without the pulse wr_buf holds.
- R3: Each cycle with cons_done high moves rd_buf the same way. Without the pulse rd_buf holds.
- R4: In block mode (mode bit 0), bank = addr[AW-1:AW-log2(BANKS)] and the in-bank offset is the remaining low bits. With the default sizes, bank = addr[3:2].
- R5: In interleaved mode (mode bit 1), bank = addr[log2(BANKS)-1:0] and the offset is the remaining high bits. With the default sizes, bank = addr[1:0].
- R6: Lanes of one port whose addresses decode to distinct banks are all served in the same cycle.
- R7: If two enabled write lanes decode to the same bank, only the lowest-indexed of them is stored, and wr_conflict is 1 in the following cycle.
- R8: If two enabled read lanes decode to the same bank, only the lowest-indexed of them returns rd_valid, and rd_conflict is 1 in the following cycle.
- R9: Read data and its per-lane rd_valid appear exactly one cycle after rd_en, and rd_valid is 0 in any cycle that follows a cycle without rd_en on that lane.
- R10: While wr_buf equals rd_buf, every write is discarded and wr_blocked is 1 in the following cycle. The buffer contents are left unchanged.
- R11: Writes and reads use the buffer selected by wr_buf and rd_buf respectively, so the same logical address in different buffers holds independent data.
- R12: cfg_mode is loaded into the decode mode register only in a cycle with cfg_we high. At other times it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load enable for the decode mode register |
| cfg_mode | input | 1 | Decode mode: 0 block, 1 interleaved |
| prod_done | input | 1 | Producer finished its buffer; advance wr_buf |
| cons_done | input | 1 | Consumer finished its buffer; advance rd_buf |
| wr_en | input | LANES | Per-lane write enable |
| wr_addr | input | LANES*AW | Per-lane logical word address, lane 0 in the low bits |
| wr_data | input | LANES*DW | Per-lane write data |
| rd_en | input | LANES | Per-lane read enable |
| rd_addr | input | LANES*AW | Per-lane logical read address |
| rd_data | output | LANES*DW | Per-lane read data, one cycle after rd_en |
| rd_valid | output | LANES | Per-lane read data valid |
| wr_blocked | output | 1 | A write was dropped because it targeted the buffer being read |
| wr_conflict | output | 1 | A write lane lost bank arbitration |
| rd_conflict | output | 1 | A read lane lost bank arbitration |
| wr_buf | output | BUFW | Current producer buffer index |
| rd_buf | output | BUFW | Current consumer buffer index |

## Verification
A wrong buffer pointer shows on wr_buf or rd_buf one edge after the done pulse. It shows again later, when a readback returns another buffer's data or a write is flagged as blocked when it should not be. A wrong decode or arbitration state shows at once as a conflict flag with the wrong value in the cycle after the access. A later readback then returns a word that was dropped or sits in the wrong place. Each stimulus pairs a two-lane write with a two-lane read and a lone read, so a misrouted lane shows up within a few cycles of its write.

// File: rtl/nbuf_pkg.sv
package nbuf_pkg;
  typedef enum logic {
    DEC_BLOCK  = 1'b0,
    DEC_CYCLIC = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/nbuf_ptr.sv
// Ring index that steps once per done pulse.
module nbuf_ptr #(
  parameter int NBUF = 3,
  parameter int BUFW = 2,
  parameter int INIT = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [BUFW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)
      idx <= BUFW'(INIT);
    else if (adv)
      idx <= (idx == BUFW'(NBUF - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/nbuf_decode.sv
// Splits one logical address into bank number and in-bank offset.
module nbuf_decode
  import nbuf_pkg::*;
#(
  parameter int AW  = 4,
  parameter int BKW = 2
) (
  input  dec_mode_e          mode,
  input  logic [AW-1:0]      addr,
  output logic [BKW-1:0]     bank,
  output logic [AW-BKW-1:0]  off
);
  always_comb begin
    if (mode == DEC_CYCLIC) begin
      bank = addr[BKW-1:0];
      off  = addr[AW-1:BKW];
    end else begin
      bank = addr[AW-1:AW-BKW];
      off  = addr[AW-BKW-1:0];
    end
  end
endmodule

// File: rtl/nbuf_arb.sv
// Fixed-priority bank arbiter: the lowest lane wins each bank.
module nbuf_arb #(
  parameter int LANES = 2,
  parameter int BANKS = 4,
  parameter int BKW   = 2,
  parameter int LW    = 1
) (
  input  logic [LANES-1:0]     req,
  input  logic [LANES*BKW-1:0] bank,
  output logic [LANES-1:0]     grant,
  output logic [BANKS-1:0]     act,
  output logic [BANKS*LW-1:0]  sel,
  output logic                 conflict
);
  always_comb begin
    act = '0;
    sel = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = LANES - 1; l >= 0; l--) begin
        if (req[l] && bank[l*BKW +: BKW] == BKW'(b)) begin
          act[b]         = 1'b1;
          sel[b*LW +: LW] = LW'(l);
        end
      end
    end
    for (int l = 0; l < LANES; l++) begin
      grant[l] = req[l] && (sel[bank[l*BKW +: BKW]*LW +: LW] == LW'(l));
    end
    conflict = |(req & ~grant);
  end
endmodule

// File: rtl/nbuf_bank.sv
// One simple dual-port bank, written for block RAM inference.
module nbuf_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 12,
  parameter int BAW   = 4
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [BAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/nbuf_scratchpad.sv
module nbuf_scratchpad
  import nbuf_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int BANKS     = 4,
  parameter int NBUF      = 3,
  parameter int BUF_WORDS = 16,
  parameter int DW        = 16,
  localparam int AW       = $clog2(BUF_WORDS),
  localparam int BUFW     = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_mode,
  input  logic                prod_done,
  input  logic                cons_done,
  input  logic [LANES-1:0]    wr_en,
  input  logic [LANES*AW-1:0] wr_addr,
  input  logic [LANES*DW-1:0] wr_data,
  input  logic [LANES-1:0]    rd_en,
  input  logic [LANES*AW-1:0] rd_addr,
  output logic [LANES*DW-1:0] rd_data,
  output logic [LANES-1:0]    rd_valid,
  output logic                wr_blocked,
  output logic                wr_conflict,
  output logic                rd_conflict,
  output logic [BUFW-1:0]     wr_buf,
  output logic [BUFW-1:0]     rd_buf
);
  localparam int BKW   = $clog2(BANKS);
  localparam int OFW   = AW - BKW;
  localparam int SLOTS = BUF_WORDS / BANKS;
  localparam int DEPTH = NBUF * SLOTS;
  localparam int BAW   = $clog2(DEPTH);
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  dec_mode_e mode_q;
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= DEC_BLOCK;
    else if (cfg_we)
      mode_q <= dec_mode_e'(cfg_mode);
  end

  nbuf_ptr #(.NBUF(NBUF), .BUFW(BUFW), .INIT(0)) u_wptr (
    .clk(clk), .rst(rst), .adv(prod_done), .idx(wr_buf));
  nbuf_ptr #(.NBUF(NBUF), .BUFW(BUFW), .INIT(NBUF - 1)) u_rptr (
    .clk(clk), .rst(rst), .adv(cons_done), .idx(rd_buf));

  // Per-lane address decode for both ports.
  logic [LANES*BKW-1:0] w_bank, r_bank;
  logic [LANES*OFW-1:0] w_off, r_off;
  for (genvar l = 0; l < LANES; l++) begin : g_dec
    nbuf_decode #(.AW(AW), .BKW(BKW)) u_wdec (
      .mode(mode_q), .addr(wr_addr[l*AW +: AW]),
      .bank(w_bank[l*BKW +: BKW]), .off(w_off[l*OFW +: OFW]));
    nbuf_decode #(.AW(AW), .BKW(BKW)) u_rdec (
      .mode(mode_q), .addr(rd_addr[l*AW +: AW]),
      .bank(r_bank[l*BKW +: BKW]), .off(r_off[l*OFW +: OFW]));
  end

  // The buffer held by the consumer is closed to the producer.
  logic             blocked_now;
  logic [LANES-1:0] w_req;
  assign blocked_now = (wr_buf == rd_buf);
  assign w_req       = blocked_now ? '0 : wr_en;

  logic [LANES-1:0]    w_grant, r_grant;
  logic [BANKS-1:0]    w_act, r_act;
  logic [BANKS*LW-1:0] w_sel, r_sel;
  logic                w_conf, r_conf;

  nbuf_arb #(.LANES(LANES), .BANKS(BANKS), .BKW(BKW), .LW(LW)) u_warb (
    .req(w_req), .bank(w_bank), .grant(w_grant), .act(w_act),
    .sel(w_sel), .conflict(w_conf));
  nbuf_arb #(.LANES(LANES), .BANKS(BANKS), .BKW(BKW), .LW(LW)) u_rarb (
    .req(rd_en), .bank(r_bank), .grant(r_grant), .act(r_act),
    .sel(r_sel), .conflict(r_conf));

  logic [BAW-1:0] w_base, r_base;
  assign w_base = BAW'(wr_buf) * BAW'(SLOTS);
  assign r_base = BAW'(rd_buf) * BAW'(SLOTS);

  logic [BANKS*DW-1:0] bank_q;
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LW-1:0]  ws, rs;
    logic [BAW-1:0] wa, ra;
    assign ws = w_sel[b*LW +: LW];
    assign rs = r_sel[b*LW +: LW];
    assign wa = w_base + BAW'(w_off[ws*OFW +: OFW]);
    assign ra = r_base + BAW'(r_off[rs*OFW +: OFW]);
    nbuf_bank #(.DW(DW), .DEPTH(DEPTH), .BAW(BAW)) u_bank (
      .clk(clk), .we(w_act[b]), .waddr(wa), .wdata(wr_data[ws*DW +: DW]),
      .re(r_act[b]), .raddr(ra), .rdata(bank_q[b*DW +: DW]));
  end

  // Registered side of the read path and the status flags.
  logic [LANES*BKW-1:0] r_bank_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= '0;
      r_bank_q    <= '0;
      wr_blocked  <= 1'b0;
      wr_conflict <= 1'b0;
      rd_conflict <= 1'b0;
    end else begin
      rd_valid    <= r_grant;
      r_bank_q    <= r_bank;
      wr_blocked  <= blocked_now && (|wr_en);
      wr_conflict <= w_conf;
      rd_conflict <= r_conf;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rout
    assign rd_data[l*DW +: DW] = bank_q[r_bank_q[l*BKW +: BKW]*DW +: DW];
  end
endmodule

// File: rtl/nbuf_scratchpad_chk.sv
module nbuf_scratchpad_chk #(
  parameter int LANES = 2,
  parameter int NBUF  = 3,
  parameter int BUFW  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             prod_done,
  input logic             cons_done,
  input logic [LANES-1:0] wr_en,
  input logic [LANES-1:0] rd_en,
  input logic [LANES-1:0] rd_valid,
  input logic             wr_blocked,
  input logic             wr_conflict,
  input logic             rd_conflict,
  input logic [BUFW-1:0]  wr_buf,
  input logic [BUFW-1:0]  rd_buf
);
  a_r2_wr_step: assert property (@(posedge clk) disable iff (rst)
    prod_done |=> wr_buf == (($past(wr_buf) == BUFW'(NBUF - 1)) ? '0 : $past(wr_buf) + 1'b1));
  a_r2_wr_hold: assert property (@(posedge clk) disable iff (rst)
    !prod_done |=> $stable(wr_buf));
  a_r3_rd_step: assert property (@(posedge clk) disable iff (rst)
    cons_done |=> rd_buf == (($past(rd_buf) == BUFW'(NBUF - 1)) ? '0 : $past(rd_buf) + 1'b1));
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !cons_done |=> $stable(rd_buf));
  a_r9_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_valid & ~$past(rd_en)) == '0);
  a_r8_lane0_served: assert property (@(posedge clk) disable iff (rst)
    rd_en[0] |=> rd_valid[0]);
  a_r8_conflict_drops: assert property (@(posedge clk) disable iff (rst)
    rd_conflict |-> $countones(rd_valid) < $countones($past(rd_en)));
  a_r7_conflict_needs_two: assert property (@(posedge clk) disable iff (rst)
    wr_conflict |-> $countones($past(wr_en)) > 1);
  a_r10_block_flag: assert property (@(posedge clk) disable iff (rst)
    ((|wr_en) && wr_buf == rd_buf) |=> wr_blocked);
  a_r10_block_cause: assert property (@(posedge clk) disable iff (rst)
    wr_blocked |-> $past(wr_buf == rd_buf));
endmodule

bind nbuf_scratchpad nbuf_scratchpad_chk #(.LANES(LANES), .NBUF(NBUF), .BUFW(BUFW)) u_chk (
  .clk(clk), .rst(rst), .prod_done(prod_done), .cons_done(cons_done),
  .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid), .wr_blocked(wr_blocked),
  .wr_conflict(wr_conflict), .rd_conflict(rd_conflict),
  .wr_buf(wr_buf), .rd_buf(rd_buf));

// File: tb/nbuf_scratchpad_bench.sv
module nbuf_scratchpad_bench;
  localparam int CLK_NS = 8;
  localparam int NV = 8;
  // Nibbles: mode, lane0 address, lane1 address, expected conflict.
  localparam logic [15:0] VEC [NV] = '{
    16'h0040, 16'h0121, 16'h1120, 16'h1371,
    16'h0F80, 16'h1C01, 16'h0DE1, 16'h15A0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_mode = 1'b0;
  logic        prod_done = 1'b0, cons_done = 1'b0;
  logic [1:0]  wr_en = '0, rd_en = '0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  rd_valid;
  logic        wr_blocked, wr_conflict, rd_conflict;
  logic [1:0]  wr_buf, rd_buf;

  int checks = 0;
  int fails  = 0;
  logic [15:0] s_d0, s_d1;
  logic [1:0]  s_val;
  logic        s_wc, s_wb, s_rc;

  always #(CLK_NS / 2) clk = ~clk;

  nbuf_scratchpad u_nbuf_scratchpad (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .prod_done(prod_done), .cons_done(cons_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_blocked(wr_blocked), .wr_conflict(wr_conflict), .rd_conflict(rd_conflict),
    .wr_buf(wr_buf), .rd_buf(rd_buf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_we = 1'b0; cfg_mode = 1'b0;
    wr_en = '0; rd_en = '0; prod_done = 1'b0; cons_done = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m;
    @(posedge clk); #1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic p, input logic c);
    @(negedge clk); prod_done = p; cons_done = c;
    @(posedge clk); #1;
    @(negedge clk); prod_done = 1'b0; cons_done = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] en, input logic [3:0] a0, input logic [15:0] d0,
                          input logic [3:0] a1, input logic [15:0] d1);
    @(negedge clk);
    wr_en = en; wr_addr = {a1, a0}; wr_data = {d1, d0};
    @(posedge clk); #1;
    s_wc = wr_conflict; s_wb = wr_blocked;
    @(negedge clk); wr_en = '0;
  endtask

  task automatic do_read(input logic [1:0] en, input logic [3:0] a0, input logic [3:0] a1);
    @(negedge clk);
    rd_en = en; rd_addr = {a1, a0};
    @(posedge clk); #1;
    s_val = rd_valid; s_rc = rd_conflict;
    s_d0 = rd_data[15:0]; s_d1 = rd_data[31:16];
    @(negedge clk); rd_en = '0;
  endtask

  initial begin : watchdog
    #(CLK_NS * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    // R1: reset state
    do_reset();
    #1;
    chk("R1 wr_buf", wr_buf, 0);
    chk("R1 rd_buf", rd_buf, 2);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 flags", {wr_blocked, wr_conflict, rd_conflict}, 0);

    // Table walk: R4/R5 decode, R6 parallel lanes, R7/R8 conflicts, R9 latency
    for (int i = 0; i < NV; i++) begin
      logic        m, ex;
      logic [3:0]  a0, a1;
      logic [15:0] d0, d1;
      string       tag;
      m  = VEC[i][12];
      a0 = VEC[i][11:8];
      a1 = VEC[i][7:4];
      ex = VEC[i][0];
      d0 = 16'hA000 + 16'(i);
      d1 = 16'hB000 + 16'(i);
      tag = m ? "R5" : "R4";
      do_reset();
      set_mode(m);
      do_write(2'b11, a0, d0, a1, d1);
      chk({tag, " R7 wr_conflict"}, s_wc, ex);
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
      do_read(2'b11, a0, a1);
      chk({tag, " R8 rd_conflict"}, s_rc, ex);
      chk("R9 lane0 valid", s_val[0], 1);
      chk({tag, " R6 lane0 data"}, s_d0, d0);
      chk("R8 R6 lane1 valid", s_val[1], !ex);
      do_read(2'b10, a0, a1);
      chk("R9 lone lane1 valid", s_val[1], 1);
      if (ex) chk("R7 dropped lane1 absent", s_d1 != d1, 1);
      else    chk({tag, " R6 lane1 data"}, s_d1, d1);
    end

    // R9: valid falls one cycle after rd_en drops
    @(posedge clk); #1;
    chk("R9 valid idle", rd_valid, 0);

    // R2/R3: pointer rotation and wrap
    do_reset();
    pulse(1'b1, 1'b0); chk("R2 wr 1", wr_buf, 1);
    pulse(1'b1, 1'b0); chk("R2 wr 2", wr_buf, 2);
    pulse(1'b1, 1'b0); chk("R2 wr wrap", wr_buf, 0);
    chk("R3 rd hold", rd_buf, 2);
    pulse(1'b0, 1'b1); chk("R3 rd wrap", rd_buf, 0);
    pulse(1'b0, 1'b1); chk("R3 rd 1", rd_buf, 1);
    chk("R2 wr hold", wr_buf, 0);

    // R10: writes to the buffer under read are dropped
    do_reset();
    do_write(2'b01, 4'd3, 16'h1111, 4'd0, 16'h0);
    chk("R10 no block", s_wb, 0);
    pulse(1'b0, 1'b1);
    do_write(2'b01, 4'd3, 16'h2222, 4'd0, 16'h0);
    chk("R10 blocked flag", s_wb, 1);
    do_read(2'b01, 4'd3, 4'd0);
    chk("R10 data unchanged", s_d0, 16'h1111);

    // R11: same address, separate buffers
    do_reset();
    do_write(2'b01, 4'd5, 16'hC0C0, 4'd0, 16'h0);
    pulse(1'b1, 1'b0);
    do_write(2'b01, 4'd5, 16'hC1C1, 4'd0, 16'h0);
    pulse(1'b1, 1'b1);
    do_read(2'b01, 4'd5, 4'd0);
    chk("R11 buffer0", s_d0, 16'hC0C0);
    pulse(1'b0, 1'b1);
    do_read(2'b01, 4'd5, 4'd0);
    chk("R11 buffer1", s_d0, 16'hC1C1);

    // R12: cfg_mode ignored without cfg_we
    do_reset();
    @(negedge clk); cfg_mode = 1'b1;
    do_write(2'b11, 4'd1, 16'h0D01, 4'd2, 16'h0D02);
    chk("R12 mode unchanged", s_wc, 1);
    set_mode(1'b1);
    do_write(2'b11, 4'd1, 16'h0D01, 4'd2, 16'h0D02);
    chk("R12 mode loaded", s_wc, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule